// File: doc/BRIEF.md
# Character I/O and Interrupt Request Unit

This block sits beside the accumulator datapath of a small stored-program computer. It moves characters between that datapath and two slow devices, one for input and one for output. Each direction has an 8-bit holding register and a one-bit ready flag. A device and the CPU pass each character to one another by setting and clearing that flag. The input device raises its flag when a fresh character has been latched. The output device raises its flag when it can take the next character.

On the CPU side the block receives one-cycle strobes from the instruction decoder:
- take the input character;
- send the accumulator's low byte out;
- test either flag for a skip;
- enable interrupts;
- disable interrupts.

It also receives a strobe marking the end of each instruction and a strobe marking an interrupt cycle. When interrupts are enabled and either flag is up, a pending request is latched at the next instruction boundary. The CPU then runs an interrupt cycle, which clears the request and the enable bit.

Top module: `acc_io_irq`

## Requirements
- R1: After reset both flags, both 8-bit buffers, the enable bit and the pending bit are 0.
- R2: An input strobe while the input flag is 0 loads `dev_in_data` into the input buffer and sets the input flag on the next clock edge.
- R3: An input strobe while the input flag is 1, without `op_inp` in the same cycle, is ignored: the input buffer and the input flag keep their values.
- R4: `op_inp` clears the input flag on the next edge. The input buffer keeps its value and stays visible on `in_buf`.
- R5: `dev_out_ack` sets the output flag. `op_out` clears it and writes `cpu_acc_lo` into the output buffer on the next edge.
- R6: When a device set and a CPU clear reach the same flag in the same cycle, the flag ends up 1. For input, the new character is also loaded.
- R7: `skip` is high in the same cycle when `op_ski` is high and the input flag is 1, or when `op_sko` is high and the output flag is 1. Otherwise `skip` is low.
- R8: `op_ion` sets the enable bit. `op_ioff` or `irq_cycle` clears it, and a clear wins over a set in the same cycle.
- R9: The pending bit becomes 1 only on an edge where `instr_end` is high, the enable bit is 1 and at least one flag is 1. It never rises without `instr_end`.
- R10: `irq_cycle` clears the pending bit on the next edge, even if `instr_end` would set it in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| dev_in_stb | input | 1 | Input device presents a character |
| dev_in_data | input | 8 | Character from the input device |
| dev_out_ack | input | 1 | Output device is ready for a character |
| cpu_acc_lo | input | 8 | Low byte of the accumulator |
| op_inp | input | 1 | Take-input instruction strobe |
| op_out | input | 1 | Send-output instruction strobe |
| op_ski | input | 1 | Skip-if-input-ready strobe |
| op_sko | input | 1 | Skip-if-output-ready strobe |
| op_ion | input | 1 | Interrupt enable strobe |
| op_ioff | input | 1 | Interrupt disable strobe |
| irq_cycle | input | 1 | CPU is in its interrupt cycle |
| instr_end | input | 1 | Current instruction completes this cycle |
| in_buf | output | 8 | Input buffer, routed to the accumulator |
| out_buf | output | 8 | Output buffer, read by the output device |
| in_flag | output | 1 | Input ready flag |
| out_flag | output | 1 | Output ready flag |
| irq_en | output | 1 | Interrupt enable bit |
| irq_pending | output | 1 | Interrupt pending bit |
| skip | output | 1 | Skip the next instruction |

## Verification
Every register in the block is due one clock edge after the strobe that changes it. `skip` is the only combinational result, so it is due within the same cycle. The driver applies each stimulus at a falling edge and queues the expected register state. The monitor pops that entry just after the next rising edge, so each compare falls in the cycle where the change must have landed. `skip` is sampled one nanosecond after the stimulus is applied, before any edge can move the flags.

// File: rtl/acc_io_irq.sv
module acc_io_irq #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dev_in_stb,
  input  logic [W-1:0] dev_in_data,
  input  logic         dev_out_ack,
  input  logic [W-1:0] cpu_acc_lo,
  input  logic         op_inp,
  input  logic         op_out,
  input  logic         op_ski,
  input  logic         op_sko,
  input  logic         op_ion,
  input  logic         op_ioff,
  input  logic         irq_cycle,
  input  logic         instr_end,
  output logic [W-1:0] in_buf,
  output logic [W-1:0] out_buf,
  output logic         in_flag,
  output logic         out_flag,
  output logic         irq_en,
  output logic         irq_pending,
  output logic         skip
);

  logic in_take;
  logic en_clr;
  logic req;

  assign in_take = dev_in_stb && (!in_flag || op_inp);
  assign en_clr  = op_ioff || irq_cycle;
  assign req     = irq_en && (in_flag || out_flag);
  assign skip    = (op_ski && in_flag) || (op_sko && out_flag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_buf  <= '0;
      in_flag <= 1'b0;
    end else begin
      if (in_take) in_buf <= dev_in_data;
      if (in_take) in_flag <= 1'b1;
      else if (op_inp) in_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_buf  <= '0;
      out_flag <= 1'b0;
    end else begin
      if (op_out) out_buf <= cpu_acc_lo;
      if (dev_out_ack) out_flag <= 1'b1;
      else if (op_out) out_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en      <= 1'b0;
      irq_pending <= 1'b0;
    end else begin
      if (en_clr) irq_en <= 1'b0;
      else if (op_ion) irq_en <= 1'b1;
      if (irq_cycle) irq_pending <= 1'b0;
      else if (instr_end && req) irq_pending <= 1'b1;
    end
  end

endmodule

// File: rtl/acc_io_irq_chk.sv
module acc_io_irq_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         dev_in_stb,
  input logic [W-1:0] dev_in_data,
  input logic         dev_out_ack,
  input logic [W-1:0] cpu_acc_lo,
  input logic         op_inp,
  input logic         op_out,
  input logic         op_ski,
  input logic         op_sko,
  input logic         op_ion,
  input logic         op_ioff,
  input logic         irq_cycle,
  input logic         instr_end,
  input logic [W-1:0] in_buf,
  input logic [W-1:0] out_buf,
  input logic         in_flag,
  input logic         out_flag,
  input logic         irq_en,
  input logic         irq_pending,
  input logic         skip
);

  p_in_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dev_in_stb && !in_flag |=> in_flag && in_buf == $past(dev_in_data));

  p_in_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dev_in_stb && in_flag && !op_inp |=> in_flag && $stable(in_buf));

  p_inp_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_inp && !dev_in_stb |=> !in_flag && $stable(in_buf));

  p_out_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_out && !dev_out_ack |=> !out_flag && out_buf == $past(cpu_acc_lo));

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dev_out_ack |=> out_flag);

  p_skip_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_flag && !out_flag |-> !skip);

  p_en_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_ioff || irq_cycle |=> !irq_en);

  p_pend_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pending) |-> $past(instr_end) && $past(irq_en));

  p_pend_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cycle |=> !irq_pending);

endmodule

bind acc_io_irq acc_io_irq_chk #(.W(W)) u_chk (.*);

// File: tb/tb_acc_io_irq.sv
`timescale 1ns/1ps
module tb_acc_io_irq;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dev_in_stb, dev_out_ack, op_inp, op_out, op_ski, op_sko;
  logic op_ion, op_ioff, irq_cycle, instr_end;
  logic [7:0] dev_in_data, cpu_acc_lo;
  logic [7:0] in_buf, out_buf;
  logic in_flag, out_flag, irq_en, irq_pending, skip;

  always #2.5 clk = ~clk;

  acc_io_irq dut (.*);

  typedef struct {
    logic [7:0] ib, ob;
    logic fi, fo, en, pd;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t m;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic cmp(string tag, exp_t e);
    checks++;
    if (in_buf !== e.ib || out_buf !== e.ob || in_flag !== e.fi ||
        out_flag !== e.fo || irq_en !== e.en || irq_pending !== e.pd) begin
      errors++;
      $display("FAIL %s: got ib=%h ob=%h fi=%b fo=%b en=%b pd=%b exp ib=%h ob=%h fi=%b fo=%b en=%b pd=%b",
               tag, in_buf, out_buf, in_flag, out_flag, irq_en, irq_pending,
               e.ib, e.ob, e.fi, e.fo, e.en, e.pd);
    end
  endtask

  task automatic idle();
    {dev_in_stb, dev_out_ack, op_inp, op_out, op_ski, op_sko} = '0;
    {op_ion, op_ioff, irq_cycle, instr_end} = '0;
    dev_in_data = 8'h00;
    cpu_acc_lo = 8'h00;
  endtask

  task automatic go(string tag);
    exp_t n;
    logic acc_in;
    n = m;
    n.tag = tag;
    acc_in = dev_in_stb && (!m.fi || op_inp);
    if (acc_in) begin n.ib = dev_in_data; n.fi = 1'b1; end
    else if (op_inp) n.fi = 1'b0;
    if (op_out) n.ob = cpu_acc_lo;
    if (dev_out_ack) n.fo = 1'b1; else if (op_out) n.fo = 1'b0;
    if (op_ioff || irq_cycle) n.en = 1'b0; else if (op_ion) n.en = 1'b1;
    if (irq_cycle) n.pd = 1'b0;
    else if (instr_end && m.en && (m.fi || m.fo)) n.pd = 1'b1;
    m = n;
    q.push_back(n);
    @(negedge clk);
    idle();
  endtask

  task automatic chk_skip(string tag, logic exp);
    #1;
    checks++;
    if (skip !== exp) begin
      errors++;
      $display("FAIL %s: skip got %b exp %b", tag, skip, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      cmp(e.tag, e);
    end
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    m = '{ib:8'h00, ob:8'h00, fi:1'b0, fo:1'b0, en:1'b0, pd:1'b0, tag:"R1"};
    repeat (3) @(negedge clk);
    cmp("R1 reset", m);
    rst_n = 1'b1;
    @(negedge clk);

    dev_in_stb = 1; dev_in_data = 8'h41; go("R2 load");
    dev_in_stb = 1; dev_in_data = 8'h42; go("R3 ignored strobe");
    op_ski = 1; chk_skip("R7 ski flag1", 1'b1); go("R7 ski");
    op_sko = 1; chk_skip("R7 sko flag0", 1'b0); go("R7 sko");
    op_inp = 1; go("R4 inp clears");
    op_ski = 1; chk_skip("R7 ski flag0", 1'b0); go("R7 ski0");
    dev_in_stb = 1; dev_in_data = 8'h43; go("R2 reload");
    op_inp = 1; dev_in_stb = 1; dev_in_data = 8'h44; go("R6 in set wins");
    dev_out_ack = 1; go("R5 ack");
    op_sko = 1; chk_skip("R7 sko flag1", 1'b1); go("R7 sko1");
    op_out = 1; cpu_acc_lo = 8'h7E; go("R5 out");
    op_out = 1; dev_out_ack = 1; cpu_acc_lo = 8'hA5; go("R6 out set wins");
    op_ion = 1; go("R8 ion");
    repeat (2) go("R9 no boundary");
    instr_end = 1; go("R9 boundary");
    irq_cycle = 1; instr_end = 1; go("R10 irq cycle");
    op_ion = 1; op_ioff = 1; go("R8 clear wins");
    instr_end = 1; go("R9 disabled");
    op_ion = 1; go("R8 ion again");
    op_inp = 1; op_out = 1; go("R4 both clear");
    instr_end = 1; go("R9 no flags");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule